// File: doc/BRIEF.md
# Dual-Rail Threshold-Gate Full Adder

This block adds three one-bit operands (A, B and carry-in) in delay-insensitive, dual-rail form. Every operand and every result travels on two wires, one for logic 0 and one for logic 1. When both wires are low the signal carries no value; this is the spacer state. A computation is a DATA wavefront on all three inputs, which produces DATA on sum and carry. It is followed by an all-spacer wavefront, which must drain the outputs back to the spacer state before the next operands arrive.

The logic is built from hysteresis threshold cells. A cell asserts once at least M of its N inputs are high. It then stays high until every input is low. Each output rail is formed by counting asserted input rails, not by decoding minterms:

- Carry uses a 2-of-3 count on each rail group.
- Sum combines at-least-1, at-least-2 and all-3 counts through a 2-of-2 cell and a 1-of-2 cell.

The two rails of each output come from separate logic, so a spacer reaches both rails. Each cell holds its state in a flip-flop clocked by a sampling clock. A synchronous reset clears every cell to the spacer state.

Top module: `ncl_full_adder`

## Requirements
- R1: Each dual-rail port encodes bit 1 as the logic-1 rail, bit 0 as the logic-0 rail. The code 2'b10 means value 1, 2'b01 means value 0, 2'b00 is the spacer, and 2'b11 is illegal.
- R2: While `rst` is high at a clock edge, both outputs read 2'b00 after that edge.
- R3: With all three inputs DATA, `sum_out` settles to the odd parity of A, B and carry-in.
- R4: With all three inputs DATA, `cout_out` settles to the majority of A, B and carry-in.
- R5: Neither output ever reads 2'b11.
- R6: From the spacer state, `sum_out` stays 2'b00 while any of the three inputs is still the spacer.
- R7: After a DATA result, `sum_out` keeps its value while at least one input is still DATA. `cout_out` keeps its value while two inputs are still DATA.
- R8: Once all inputs are the spacer, `cout_out` reads 2'b00 after one clock edge and `sum_out` reads 2'b00 after at most three edges.
- R9: After all inputs become DATA, `cout_out` is valid after one edge. `sum_out` is still 2'b00 after one edge and valid after three edges.
- R10: Carry resolves as soon as two inputs carry the same value, even while the third is still the spacer. In that case it is 2'b10 for two ones and 2'b01 for two zeros; one 1 and one 0 leave it at 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock that updates every threshold cell |
| rst | input | 1 | Synchronous active-high reset to the spacer state |
| a_in | input | 2 | Operand A, dual-rail {logic-1 rail, logic-0 rail} |
| b_in | input | 2 | Operand B, dual-rail {logic-1 rail, logic-0 rail} |
| c_in | input | 2 | Carry-in, dual-rail {logic-1 rail, logic-0 rail} |
| sum_out | output | 2 | Sum, dual-rail {logic-1 rail, logic-0 rail} |
| cout_out | output | 2 | Carry-out, dual-rail {logic-1 rail, logic-0 rail} |

## Verification
A count cell stuck high, or one that fails to release, shows at the ports in one of two ways:

- An output reads 2'b11.
- An output stays DATA after an all-spacer wavefront. This is visible within three sampling edges for sum and one edge for carry.

A cell that fires too early shows as a sum value appearing while one operand is still the spacer. A wrong threshold or a crossed rail shows as a wrong parity or majority value in one of the eight operand patterns, three edges after the operands land. A cell that lacks hysteresis shows as a result dropping when only some of the operands have returned to the spacer.

// File: rtl/ncl_fa_pkg.sv
package ncl_fa_pkg;

    // One dual-rail signal: logic-1 rail in the upper bit (R1).
    typedef struct packed {
        logic r1;
        logic r0;
    } dual_rail_t;

    localparam dual_rail_t DR_SPACER = '{r1: 1'b0, r0: 1'b0};
    localparam int FA_OPERANDS = 3;

    function automatic logic dr_is_data(input dual_rail_t s);
        return s.r1 ^ s.r0;
    endfunction

    function automatic logic dr_is_spacer(input dual_rail_t s);
        return !(s.r1 || s.r0);
    endfunction

endpackage

// File: rtl/ncl_th_cell.sv
// Hysteresis threshold cell: sets once THRESH of N_IN inputs are high,
// clears only when every input is low, otherwise keeps its state.
module ncl_th_cell #(
    parameter int N_IN   = 3,
    parameter int THRESH = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_IN-1:0] rails,
    output logic            fire
);
    localparam int CNT_W = $clog2(N_IN + 1);

    logic [CNT_W-1:0] high_cnt;
    logic             set_now;
    logic             clear_now;

    always_comb begin
        high_cnt  = CNT_W'($countones(rails));
        set_now   = (int'(high_cnt) >= THRESH);
        clear_now = (rails == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fire <= 1'b0;
        end else if (set_now) begin
            fire <= 1'b1;
        end else if (clear_now) begin
            fire <= 1'b0;
        end
    end
endmodule

// File: rtl/ncl_count_plane.sv
// Counts asserted rails of one polarity: at_least[k] is a k-of-N_IN cell.
module ncl_count_plane #(
    parameter int N_IN = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_IN-1:0] rails,
    output logic [N_IN:1]   at_least
);
    for (genvar k = 1; k <= N_IN; k++) begin : g_thresh
        ncl_th_cell #(
            .N_IN  (N_IN),
            .THRESH(k)
        ) u_th (
            .clk  (clk),
            .rst  (rst),
            .rails(rails),
            .fire (at_least[k])
        );
    end
endmodule

// File: rtl/ncl_full_adder.sv
module ncl_full_adder
    import ncl_fa_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] a_in,
    input  logic [1:0] b_in,
    input  logic [1:0] c_in,
    output logic [1:0] sum_out,
    output logic [1:0] cout_out
);
    localparam int N = FA_OPERANDS;

    dual_rail_t a_dr, b_dr, c_dr;
    dual_rail_t sum_dr, cout_dr;
    logic [N-1:0] ones_rails, zeros_rails;
    logic [N:1]   ones_ge, zeros_ge;
    logic         odd_single, even_pair;

    always_comb begin
        a_dr        = dual_rail_t'(a_in);
        b_dr        = dual_rail_t'(b_in);
        c_dr        = dual_rail_t'(c_in);
        ones_rails  = {c_dr.r1, b_dr.r1, a_dr.r1};
        zeros_rails = {c_dr.r0, b_dr.r0, a_dr.r0};
    end

    // Level 1: how many operands are 1, how many are 0.
    ncl_count_plane #(.N_IN(N)) u_ones (
        .clk(clk), .rst(rst), .rails(ones_rails), .at_least(ones_ge)
    );
    ncl_count_plane #(.N_IN(N)) u_zeros (
        .clk(clk), .rst(rst), .rails(zeros_rails), .at_least(zeros_ge)
    );

    // Level 2: exactly one 1 (>=1 ones and >=2 zeros), exactly two 1s.
    ncl_th_cell #(.N_IN(2), .THRESH(2)) u_odd_single (
        .clk(clk), .rst(rst),
        .rails({ones_ge[1], zeros_ge[2]}), .fire(odd_single)
    );
    ncl_th_cell #(.N_IN(2), .THRESH(2)) u_even_pair (
        .clk(clk), .rst(rst),
        .rails({ones_ge[2], zeros_ge[1]}), .fire(even_pair)
    );

    // Level 3: merge with the all-ones / all-zeros terms.
    ncl_th_cell #(.N_IN(2), .THRESH(1)) u_sum_one (
        .clk(clk), .rst(rst),
        .rails({ones_ge[3], odd_single}), .fire(sum_dr.r1)
    );
    ncl_th_cell #(.N_IN(2), .THRESH(1)) u_sum_zero (
        .clk(clk), .rst(rst),
        .rails({zeros_ge[3], even_pair}), .fire(sum_dr.r0)
    );

    // Carry reuses the shared 2-of-3 cells.
    always_comb begin
        cout_dr.r1 = ones_ge[2];
        cout_dr.r0 = zeros_ge[2];
        sum_out    = sum_dr;
        cout_out   = cout_dr;
    end
endmodule

// File: rtl/ncl_fa_checker.sv
module ncl_fa_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] a_in,
    input logic [1:0] b_in,
    input logic [1:0] c_in,
    input logic [1:0] sum_out,
    input logic [1:0] cout_out
);
    logic [2:0] ones_in, zeros_in;
    always_comb begin
        ones_in  = {a_in[1], b_in[1], c_in[1]};
        zeros_in = {a_in[0], b_in[0], c_in[0]};
    end

    AST_SUM_NOT_BOTH: assert property (@(posedge clk) disable iff (rst)
        sum_out != 2'b11); // R5
    AST_COUT_NOT_BOTH: assert property (@(posedge clk) disable iff (rst)
        cout_out != 2'b11); // R5
    AST_RESET_SPACER: assert property (@(posedge clk)
        rst |=> (sum_out == 2'b00 && cout_out == 2'b00)); // R2
    AST_COUT_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (ones_in == 3'b000 && zeros_in == 3'b000) |=> cout_out == 2'b00); // R8
    AST_COUT_ONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cout_out[1] && $countones(ones_in) != 0) |=> cout_out[1]); // R7
    AST_COUT_ZERO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cout_out[0] && $countones(zeros_in) != 0) |=> cout_out[0]); // R7
    AST_COUT_ONE_MAJ: assert property (@(posedge clk) disable iff (rst)
        $rose(cout_out[1]) |-> $past($countones(ones_in)) >= 2); // R4
    AST_COUT_ZERO_MAJ: assert property (@(posedge clk) disable iff (rst)
        $rose(cout_out[0]) |-> $past($countones(zeros_in)) >= 2); // R4
endmodule

bind ncl_full_adder ncl_fa_checker u_chk (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .c_in(c_in),
    .sum_out(sum_out), .cout_out(cout_out)
);

// File: tb/sim_ncl_full_adder.sv
module sim_ncl_full_adder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] a_in = 2'b00, b_in = 2'b00, c_in = 2'b00;
    logic [1:0] sum_out, cout_out;

    int n_checks = 0;
    int n_fails  = 0;

    localparam logic [1:0] SP = 2'b00;

    always #10 clk = ~clk; // 50 MHz

    ncl_full_adder u0 (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .c_in(c_in),
        .sum_out(sum_out), .cout_out(cout_out)
    );

    // R1 encoding: 1 -> 2'b10, 0 -> 2'b01, spacer 2'b00.
    function automatic logic [1:0] enc(input logic v);
        return v ? 2'b10 : 2'b01;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [1:0] got, input logic [1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input logic [1:0] a, input logic [1:0] b,
                         input logic [1:0] c);
        a_in = a; b_in = b; c_in = c;
    endtask

    task automatic t_reset;
        step(3);
        check("R2", "sum in reset", sum_out, SP);
        check("R2", "cout in reset", cout_out, SP);
        rst = 1'b0;
        step(2);
        check("R2", "sum after reset", sum_out, SP);
        check("R2", "cout after reset", cout_out, SP);
    endtask

    task automatic t_truth_table;
        for (int v = 0; v < 8; v++) begin
            logic x, y, z;
            x = v[2]; y = v[1]; z = v[0];
            drive(enc(x), enc(y), enc(z));
            step(3);
            check("R3", "sum parity", sum_out, enc(x ^ y ^ z));
            check("R4", "cout majority", cout_out, enc((x & y) | (x & z) | (y & z)));
            n_checks++;
            if (sum_out == 2'b11 || cout_out == 2'b11) begin
                n_fails++;
                $display("FAIL R5 both rails: actual %b/%b expected not 11",
                         sum_out, cout_out);
            end
            drive(SP, SP, SP);
            step(3);
            check("R8", "sum drained", sum_out, SP);
            check("R8", "cout drained", cout_out, SP);
        end
    endtask

    task automatic t_partial_data;
        for (int v = 0; v < 4; v++) begin
            for (int miss = 0; miss < 3; miss++) begin
                logic [1:0] p, q;
                p = enc(v[1]); q = enc(v[0]);
                case (miss)
                    0: drive(SP, p, q);
                    1: drive(p, SP, q);
                    default: drive(p, q, SP);
                endcase
                step(4);
                check("R6", "sum waits for all operands", sum_out, SP);
                if (v == 3)
                    check("R10", "early carry two ones", cout_out, 2'b10);
                else if (v == 0)
                    check("R10", "early carry two zeros", cout_out, 2'b01);
                else
                    check("R10", "no early carry mixed", cout_out, SP);
                drive(SP, SP, SP);
                step(3);
                check("R8", "sum drained partial", sum_out, SP);
            end
        end
    endtask

    task automatic t_partial_null;
        for (int v = 0; v < 8; v++) begin
            logic [1:0] es, ec;
            es = enc(v[2] ^ v[1] ^ v[0]);
            ec = enc((v[2] & v[1]) | (v[2] & v[0]) | (v[1] & v[0]));
            drive(enc(v[2]), enc(v[1]), enc(v[0]));
            step(4);
            drive(SP, b_in, c_in);
            step(4);
            check("R7", "sum holds one spacer", sum_out, es);
            check("R7", "cout holds one spacer", cout_out, ec);
            drive(SP, SP, c_in);
            step(4);
            check("R7", "sum holds two spacers", sum_out, es);
            drive(SP, SP, SP);
            step(1);
            check("R8", "cout drains in one edge", cout_out, SP);
            step(2);
            check("R8", "sum drains in three edges", sum_out, SP);
        end
    endtask

    task automatic t_latency;
        drive(enc(1'b1), enc(1'b0), enc(1'b0));
        step(1);
        check("R9", "cout after one edge", cout_out, 2'b01);
        check("R9", "sum not yet after one edge", sum_out, SP);
        step(2);
        check("R9", "sum after three edges", sum_out, 2'b10);
        drive(SP, SP, SP);
        step(4);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fails);
        $finish;
    endtask

    initial begin
        t_reset();
        t_truth_table();
        t_partial_data();
        t_partial_null();
        t_latency();
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end
endmodule